// File: doc/BRIEF.md
# ADC command queue sequencer

This block moves conversion command words from a command FIFO to one of four conversion buffers. Each command carries a small control field in its top eight bits. The block decodes that field, steers the command to the chosen buffer and passes the rest of the word along. A per-queue status machine decides when words may flow. The machine has three states: idle, waiting for a trigger, and running.

Software arms the queue with a one-cycle pulse. The two-bit mode input selects the arm behaviour:
- In the two edge-triggered modes, arming parks the queue until a rising edge on the trigger input.
- In the two software modes, arming starts transfers at once.

A pause marker inside a queue splits it into sub-queues, and each sub-queue waits for its own trigger edge. An end-of-queue marker closes one pass through the queue and clears the transfer counter. Sticky pause and end-of-queue flags report both events. Each flag is cleared by a write-one-to-clear pulse.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: Control bits are numbered from the word's MSB (bit 0 = bit CMD_W-1): bit 0 end-of-queue, bit 1 pause, bits 2..4 reserved and ignored, bit 5 external buffer, bit 6 buffer number, bit 7 calibrate. `dst_sel_o` = {external, buffer number}, so 0 and 1 are the internal converters and 2 and 3 are the external buffers. `dst_data_o` is the low CMD_W-8 bits of the word, unchanged.
- R2: `dst_cal_o` equals the calibrate bit of the command currently presented.
- R3: A command is popped only in the running state and only when `dst_ready_i` is high. `cmd_ready_o` is low in every other case, so a stalled command stays in the FIFO. `dst_valid_o` is high when the state is running and `cmd_valid_i` is high.
- R4: States are encoded idle=0, waiting=1, running=2. Mode encoding: bit 1 = software start (1) or edge trigger (0), and bit 0 = continuous scan (1) or single scan (0). An arm pulse in idle moves to waiting in the edge modes and to running in the software modes. An arm pulse in any other state has no effect.
- R5: In waiting, a rising edge on `trig_i` moves the queue to running one cycle later. A trigger held high without a new edge leaves the queue waiting.
- R6: Each accepted transfer without end-of-queue increments the transfer counter by one.
- R7: An accepted end-of-queue transfer sets the counter to 0 and sets the end-of-queue flag.
- R8: After an end-of-queue transfer the next state depends on the mode:
  - single scan returns to idle;
  - continuous edge-trigger mode returns to waiting;
  - continuous software mode stays running.
- R9: An accepted pause transfer sets the pause flag. In the edge modes it also moves the queue to waiting. In the software modes the state is not changed.
- R10: A command with both pause and end-of-queue set raises both flags, and the next state is the one end-of-queue alone would give.
- R11: Each flag is cleared by a one-cycle pulse on its clear input. When a clear and a set arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Scan mode: bit 1 software start, bit 0 continuous |
| arm_i | input | 1 | One-cycle software enable pulse |
| trig_i | input | 1 | Trigger input, rising edge is the event |
| cmd_valid_i | input | 1 | Command FIFO has a word |
| cmd_data_i | input | CMD_W | Command word, control field in top 8 bits |
| cmd_ready_o | output | 1 | Pop strobe to the command FIFO |
| dst_valid_o | output | 1 | Routed command valid |
| dst_ready_i | input | 1 | Destination can accept |
| dst_sel_o | output | 2 | Buffer select {external, number} |
| dst_cal_o | output | 1 | Calibrate request of routed command |
| dst_data_o | output | CMD_W-8 | Command payload |
| eoq_flag_o | output | 1 | Sticky end-of-queue flag |
| pause_flag_o | output | 1 | Sticky pause flag |
| eoq_clr_i | input | 1 | Clear pulse for end-of-queue flag |
| pause_clr_i | input | 1 | Clear pulse for pause flag |
| xfer_cnt_o | output | CNT_W | Transfer counter |
| state_o | output | 2 | Queue status |

## Verification
Results are due at two different times:
- Routing, the calibrate pass-through and the pop strobe are combinational. They are valid in the same cycle as the command, so the bench checks them a short delay after driving the inputs on the falling edge, before the next rising edge.
- The state, the counter and the flags come from one register stage. Their new values are due one rising edge after the accepted transfer, arm pulse, trigger edge or clear pulse, so the bench checks them at the falling edge that follows that rising edge.

A trigger edge therefore shows as the running state one edge later, and the next command can be taken in that same cycle. The bench stays in reset until the two-stage reset synchronizer has released before it drives any stimulus.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } q_state_e;

  typedef struct packed {
    logic eoq;
    logic pause;
    logic ext;
    logic bnum;
    logic cal;
  } cmd_ctl_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/seq_cmd_decode.sv
module seq_cmd_decode
  import adc_seq_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic [CMD_W-1:0] word_i,
  output cmd_ctl_t         ctl_o,
  output logic [CMD_W-9:0] payload_o
);

  localparam int TOP = CMD_W - 1;

  logic unused_rsvd;

  // MSB-first numbering: control bit k lives at word bit TOP-k
  assign ctl_o.eoq   = word_i[TOP];
  assign ctl_o.pause = word_i[TOP-1];
  assign ctl_o.ext   = word_i[TOP-5];
  assign ctl_o.bnum  = word_i[TOP-6];
  assign ctl_o.cal   = word_i[TOP-7];
  assign payload_o   = word_i[CMD_W-9:0];
  assign unused_rsvd = ^word_i[TOP-2:TOP-4];

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] mode_i,
  input  logic     arm_i,
  input  logic     trig_i,
  input  logic     xfer_i,
  input  logic     eoq_i,
  input  logic     pause_i,
  output q_state_e state_o
);

  q_state_e state_q, state_d;
  logic     trig_q;
  logic     trig_rise;
  logic     sw_mode;
  logic     cont_mode;

  assign sw_mode   = mode_i[1];
  assign cont_mode = mode_i[0];
  assign trig_rise = trig_i & ~trig_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (arm_i) state_d = sw_mode ? ST_RUN : ST_WAIT;
      ST_WAIT: if (trig_rise) state_d = ST_RUN;
      ST_RUN: begin
        if (xfer_i) begin
          if (eoq_i) begin
            if (!cont_mode)   state_d = ST_IDLE;
            else if (sw_mode) state_d = ST_RUN;
            else              state_d = ST_WAIT;
          end else if (pause_i && !sw_mode) begin
            state_d = ST_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_i;
    end
  end

  assign state_o = state_q;

  // R5
  trig_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && trig_i && !trig_q) |=> (state_q == ST_RUN));

  // R9
  pause_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && pause_i && !eoq_i && !mode_i[1]) |=> (state_q == ST_WAIT));

  // R8
  eoq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && eoq_i && !mode_i[0]) |=> (state_q == ST_IDLE));

  // R4
  arm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !trig_i) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/seq_track.sv
module seq_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_i,
  input  logic             eoq_i,
  input  logic             pause_i,
  input  logic             eoq_clr_i,
  input  logic             pause_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             eoq_flag_o,
  output logic             pause_flag_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             eoq_q, eoq_d;
  logic             pau_q, pau_d;
  logic             cnt_en;

  assign cnt_en = xfer_i;

  always_comb begin
    cnt_d = eoq_i ? '0 : cnt_q + 1'b1;
    eoq_d = (xfer_i & eoq_i)   | (eoq_q & ~eoq_clr_i);
    pau_d = (xfer_i & pause_i) | (pau_q & ~pause_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      eoq_q <= 1'b0;
      pau_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      eoq_q <= eoq_d;
      pau_q <= pau_d;
    end
  end

  assign cnt_o        = cnt_q;
  assign eoq_flag_o   = eoq_q;
  assign pause_flag_o = pau_q;

  // R7
  eoq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && eoq_i) |=> (cnt_o == '0 && eoq_flag_o));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && !eoq_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && pause_i && pause_clr_i) |=> pause_flag_o);

  // R10
  both_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_i && pause_i && eoq_i) |=> (pause_flag_o && eoq_flag_o));

endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import adc_seq_pkg::*;
#(
  parameter int CMD_W = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             arm_i,
  input  logic             trig_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_data_i,
  output logic             cmd_ready_o,
  output logic             dst_valid_o,
  input  logic             dst_ready_i,
  output logic [1:0]       dst_sel_o,
  output logic             dst_cal_o,
  output logic [CMD_W-9:0] dst_data_o,
  output logic             eoq_flag_o,
  output logic             pause_flag_o,
  input  logic             eoq_clr_i,
  input  logic             pause_clr_i,
  output logic [CNT_W-1:0] xfer_cnt_o,
  output logic [1:0]       state_o
);

  logic     rst_n_s;
  cmd_ctl_t ctl;
  q_state_e state;
  logic     running;
  logic     xfer;

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  seq_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .word_i    (cmd_data_i),
    .ctl_o     (ctl),
    .payload_o (dst_data_o)
  );

  assign running     = (state == ST_RUN);
  assign dst_valid_o = running & cmd_valid_i;
  assign cmd_ready_o = running & dst_ready_i;
  assign xfer        = cmd_valid_i & cmd_ready_o;
  assign dst_sel_o   = {ctl.ext, ctl.bnum};
  assign dst_cal_o   = ctl.cal;

  seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .mode_i  (mode_i),
    .arm_i   (arm_i),
    .trig_i  (trig_i),
    .xfer_i  (xfer),
    .eoq_i   (ctl.eoq),
    .pause_i (ctl.pause),
    .state_o (state)
  );

  seq_track #(.CNT_W(CNT_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .xfer_i       (xfer),
    .eoq_i        (ctl.eoq),
    .pause_i      (ctl.pause),
    .eoq_clr_i    (eoq_clr_i),
    .pause_clr_i  (pause_clr_i),
    .cnt_o        (xfer_cnt_o),
    .eoq_flag_o   (eoq_flag_o),
    .pause_flag_o (pause_flag_o)
  );

  assign state_o = state;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dst_valid_o && !dst_ready_i) |=> $stable(xfer_cnt_o));

  // R3
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_ready_o |-> (state_o == 2'd2));

endmodule

// File: tb/adc_cmd_sequencer_bench.sv
module adc_cmd_sequencer_bench;

  localparam int CMD_W = 32;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic             arm, trig, cvalid, dready, eclr, pclr;
  logic [CMD_W-1:0] cdata;
  logic             cready, dvalid, dcal, eflag, pflag;
  logic [1:0]       dsel, st;
  logic [CMD_W-9:0] ddata;
  logic [CNT_W-1:0] cnt;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  adc_cmd_sequencer #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_adc_cmd_sequencer (
    .clk (clk), .rst_n (rst_n), .mode_i (mode), .arm_i (arm), .trig_i (trig),
    .cmd_valid_i (cvalid), .cmd_data_i (cdata), .cmd_ready_o (cready),
    .dst_valid_o (dvalid), .dst_ready_i (dready), .dst_sel_o (dsel),
    .dst_cal_o (dcal), .dst_data_o (ddata), .eoq_flag_o (eflag),
    .pause_flag_o (pflag), .eoq_clr_i (eclr), .pause_clr_i (pclr),
    .xfer_cnt_o (cnt), .state_o (st)
  );

  function automatic logic [CMD_W-1:0] mk(input logic e, input logic p,
      input logic x, input logic b, input logic c, input logic [CMD_W-9:0] pl);
    return {e, p, 3'b101, x, b, c, pl};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [CMD_W-1:0] w);
    cvalid = 1'b1; cdata = w; dready = 1'b1;
    step();
    cvalid = 1'b0;
  endtask

  task automatic trig_edge();
    trig = 1'b0; step();
    trig = 1'b1; step();
  endtask

  task automatic t_reset_state();
    chk("R4 reset state", st, 0);
    chk("R7 reset count", cnt, 0);
    chk("R11 reset flags", {eflag, pflag}, 0);
    chk("R3 reset ready", cready, 0);
  endtask

  task automatic t_arm_trigger();
    mode = 2'b00; trig = 1'b0;
    cvalid = 1'b1; cdata = mk(0, 0, 0, 0, 0, 24'h1); dready = 1'b1;
    #1 chk("R3 idle no pop", {cready, dvalid}, 0);
    cvalid = 1'b0;
    arm = 1'b1; step(); arm = 1'b0;
    chk("R4 arm edge mode", st, 1);
    arm = 1'b1; step(); arm = 1'b0;
    chk("R4 arm ignored in wait", st, 1);
    trig = 1'b1; step();
    chk("R5 edge starts run", st, 2);
  endtask

  task automatic t_route();
    cvalid = 1'b1; cdata = mk(0, 0, 1, 0, 1, 24'hABCDE); dready = 1'b1;
    #1;
    chk("R1 sel ext0", dsel, 2);
    chk("R1 payload", ddata, 24'hABCDE);
    chk("R2 cal set", dcal, 1);
    chk("R3 pop", {cready, dvalid}, 2'b11);
    step(); cvalid = 1'b0;
    chk("R6 count 1", cnt, 1);
    cvalid = 1'b1; cdata = mk(0, 0, 0, 1, 0, 24'h00055); #1;
    chk("R1 sel int1", dsel, 1);
    chk("R2 cal clear", dcal, 0);
    step(); cvalid = 1'b0;
    chk("R6 count 2", cnt, 2);
    chk("R6 still running", st, 2);
  endtask

  task automatic t_stall();
    cvalid = 1'b1; cdata = mk(0, 0, 1, 1, 0, 24'h7); dready = 1'b0; #1;
    chk("R3 stalled no pop", cready, 0);
    chk("R3 stalled valid", dvalid, 1);
    step();
    chk("R3 stall keeps count", cnt, 2);
    dready = 1'b1; step(); cvalid = 1'b0;
    chk("R6 after stall", cnt, 3);
  endtask

  task automatic t_pause();
    send(mk(0, 1, 0, 0, 0, 24'h9));
    chk("R9 pause parks", st, 1);
    chk("R9 pause flag", pflag, 1);
    chk("R6 pause counts", cnt, 4);
    cvalid = 1'b1; dready = 1'b1; #1;
    chk("R3 no pop in wait", cready, 0);
    step(); cvalid = 1'b0;
    chk("R5 held level no wake", st, 1);
    trig_edge();
    chk("R5 new edge wakes", st, 2);
  endtask

  task automatic t_clear();
    pclr = 1'b1; step(); pclr = 1'b0;
    chk("R11 clear pause", pflag, 0);
    pclr = 1'b1; send(mk(0, 1, 0, 0, 0, 24'h3)); pclr = 1'b0;
    chk("R11 set wins", pflag, 1);
    chk("R6 count 5", cnt, 5);
    trig_edge();
    chk("R5 rewake", st, 2);
  endtask

  task automatic t_eoq_single();
    send(mk(1, 0, 0, 0, 0, 24'h4));
    chk("R7 count zero", cnt, 0);
    chk("R7 eoq flag", eflag, 1);
    chk("R8 single to idle", st, 0);
  endtask

  task automatic t_both();
    eclr = 1'b1; pclr = 1'b1; step(); eclr = 1'b0; pclr = 1'b0;
    chk("R11 both cleared", {eflag, pflag}, 0);
    arm = 1'b1; step(); arm = 1'b0;
    trig_edge();
    send(mk(0, 0, 0, 0, 0, 24'h1));
    send(mk(1, 1, 0, 0, 0, 24'h2));
    chk("R10 both flags", {eflag, pflag}, 2'b11);
    chk("R10 eoq state wins", st, 0);
    chk("R10 count zero", cnt, 0);
  endtask

  task automatic t_continuous();
    mode = 2'b01;
    arm = 1'b1; step(); arm = 1'b0;
    trig_edge();
    send(mk(0, 0, 0, 0, 0, 24'h1));
    chk("R6 cont count", cnt, 1);
    send(mk(1, 0, 0, 0, 0, 24'h2));
    chk("R8 cont edge to wait", st, 1);
    chk("R7 cont zero", cnt, 0);
  endtask

  task automatic t_software();
    trig_edge();
    mode = 2'b10;
    send(mk(1, 0, 0, 0, 0, 24'h0));
    chk("R8 back to idle", st, 0);
    pclr = 1'b1; step(); pclr = 1'b0;
    arm = 1'b1; step(); arm = 1'b0;
    chk("R4 sw arm runs", st, 2);
    send(mk(0, 1, 0, 0, 0, 24'h5));
    chk("R9 sw pause no park", st, 2);
    chk("R9 sw pause flag", pflag, 1);
    mode = 2'b11;
    send(mk(1, 0, 0, 0, 0, 24'h6));
    chk("R8 cont sw stays", st, 2);
    chk("R7 sw zero", cnt, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b00; arm = 1'b0; trig = 1'b0; cvalid = 1'b0;
    cdata = '0; dready = 1'b0; eclr = 1'b0; pclr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_arm_trigger();
    t_route();
    t_stall();
    t_pause();
    t_clear();
    t_eoq_single();
    t_both();
    t_continuous();
    t_software();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule